// File: doc/BRIEF.md
# Redundant-Read Vote and Average Combiner

This unit turns several digital readings of one stored weight into a single result. It has two modes. A critical weight is stored as three copies at consecutive addresses. The unit reads all three and resolves them with a bitwise two-out-of-three vote. It also raises a flag when the copies do not all agree, so that the fault can be logged. Any other weight sits in one cell. That cell is read either two or five times, and the readings are averaged with round-to-nearest. Five reads cut random read noise by roughly the square root of five.

A pulse on `start` launches an operation, with the mode, read count and base address given alongside it. The unit then issues one read request at a time on a request/acknowledge port and accumulates the returned codes. When it is done it presents the result with a one-cycle valid strobe. The analog sensing, the conversion and the decision about where weights are placed all live outside this block.

Top module: `redread_combiner`

## Requirements
- R1: With `crit_mode`=1 the unit reads exactly three codes, from `base_addr`, then `base_addr`+1, then `base_addr`+2. Each bit of `res_data` is (a&b)|(a&c)|(b&c) over the three codes a, b and c.
- R2: In vote mode, `res_data` equals the true value when any single copy (first, second or third) holds an arbitrary wrong code.
- R3: `res_disagree` is 1 exactly when `res_valid` is 1, the operation was in vote mode, and the three codes were not all equal. In every other cycle it is 0.
- R4: With `crit_mode`=0 and `five_reads`=1 the unit reads `base_addr` five times. `res_data` is floor((sum+2)/5), where sum is the total of the five codes.
- R5: With `crit_mode`=0 and `five_reads`=0 the unit reads `base_addr` twice. `res_data` is floor((sum+1)/2).
- R6: `rd_req` is 0 while the unit is idle. Once raised, it stays high with a stable `rd_addr` until a cycle in which `rd_ack` is 1. `rd_data` is taken in that cycle, and at most one read is outstanding at any time.
- R7: `res_valid` is high for exactly one cycle: the cycle after the clock edge that samples the last `rd_ack`.
- R8: `busy` goes high in the cycle after `start` is accepted and stays high through the last acknowledge; it is 0 while `res_valid` is 1. A `start` pulse seen while `busy` is 1 has no effect on the reads issued or on the result.
- R9: After reset, `rd_req`, `res_valid`, `res_disagree` and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Launch pulse, accepted when idle |
| crit_mode | input | 1 | 1: three-copy vote, 0: averaging |
| five_reads | input | 1 | Averaging read count: 1 gives five reads, 0 gives two |
| base_addr | input | AW | Address of the first copy or of the averaged cell |
| rd_req | output | 1 | Read request |
| rd_addr | output | AW | Read address |
| rd_ack | input | 1 | Read acknowledge, qualifies `rd_data` |
| rd_data | input | DW | Returned code |
| busy | output | 1 | Operation in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | DW | Voted or averaged result |
| res_disagree | output | 1 | Copies differed (vote mode, with `res_valid`) |

## Verification
Two cases are the hardest to reach from the ports. The first is a single bad copy sitting in each of the three positions, with every possible true value. The second is a sum whose fifth or half lies right next to a rounding step. The stimulus sweeps all 256 true values against every fault position, with and without a fault, and drives five-read and two-read sets whose sums fall on both sides of each rounding point. The read acknowledge arrives after a varying number of wait cycles. A second `start` is also injected while an operation is running, so that any corruption of the latched mode or the read count shows up in the result.

// File: rtl/rr_pkg.sv
package rr_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_READ = 1'b1
  } rr_state_e;
endpackage

// File: rtl/rr_rstsync.sv
module rr_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;
endmodule

// File: rtl/rr_vote.sv
module rr_vote #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] code_a,
  input  logic [DW-1:0] code_b,
  input  logic [DW-1:0] code_c,
  output logic [DW-1:0] voted,
  output logic          differ
);
  // two-out-of-three per bit, one slice per bit position
  for (genvar g = 0; g < DW; g++) begin : g_bit
    assign voted[g] = (code_a[g] & code_b[g]) | (code_a[g] & code_c[g]) |
                      (code_b[g] & code_c[g]);
  end

  assign differ = (code_a != code_b) || (code_b != code_c);
endmodule

// File: rtl/rr_mean.sv
module rr_mean #(
  parameter int DW = 8,
  parameter int SW = DW + 3
) (
  input  logic [SW-1:0] sum,
  input  logic          by_five,
  output logic [DW-1:0] mean
);
  // reciprocal of five: shift chosen so the floor is exact over the sum range
  localparam int SH = SW + 3;
  localparam int PW = SW + SH + 1;
  localparam longint unsigned RECIP = ((64'd1 << SH) + 64'd4) / 64'd5;
  localparam logic [PW-1:0] RECIP_C = PW'(RECIP);

  logic [SW-1:0] biased5;
  logic [PW-1:0] prod;
  logic [SW-1:0] biased2;

  always_comb begin
    biased5 = sum + SW'(2);
    prod    = PW'(biased5) * RECIP_C;
    biased2 = sum + SW'(1);
    if (by_five) mean = DW'(prod >> SH);
    else         mean = DW'(biased2 >> 1);
  end
endmodule

// File: rtl/rr_seq.sv
module rr_seq
  import rr_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          crit_in,
  input  logic          five_in,
  input  logic [AW-1:0] base_in,
  input  logic          rd_ack,
  output logic          busy,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  output logic          take,
  output logic          take_last,
  output logic [2:0]    idx,
  output logic          crit_q,
  output logic          five_q
);
  rr_state_e     state_q, state_n;
  logic [2:0]    cnt_q, cnt_n;
  logic [AW-1:0] base_q;
  logic          launch;
  logic [2:0]    last_idx;

  assign launch   = (state_q == ST_IDLE) && start;
  assign last_idx = crit_q ? 3'd2 : (five_q ? 3'd4 : 3'd1);
  assign busy     = (state_q == ST_READ);
  assign rd_req   = busy;
  assign rd_addr  = base_q + (crit_q ? AW'(cnt_q) : '0);
  assign take     = busy && rd_ack;
  assign take_last = take && (cnt_q == last_idx);
  assign idx      = cnt_q;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    if (launch) begin
      state_n = ST_READ;
      cnt_n   = 3'd0;
    end else if (take_last) begin
      state_n = ST_IDLE;
      cnt_n   = 3'd0;
    end else if (take) begin
      cnt_n   = cnt_q + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= 3'd0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crit_q <= 1'b0;
      five_q <= 1'b0;
      base_q <= '0;
    end else if (launch) begin
      crit_q <= crit_in;
      five_q <= five_in;
      base_q <= base_in;
    end
  end
endmodule

// File: rtl/redread_combiner.sv
module redread_combiner #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          crit_mode,
  input  logic          five_reads,
  input  logic [AW-1:0] base_addr,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [DW-1:0] rd_data,
  output logic          busy,
  output logic          res_valid,
  output logic [DW-1:0] res_data,
  output logic          res_disagree
);
  localparam int SW = DW + 3;

  logic          srst_n;
  logic          take, take_last, crit_q, five_q;
  logic [2:0]    idx;
  logic [DW-1:0] cap0_q, cap1_q;
  logic [SW-1:0] acc_q, acc_n;
  logic [DW-1:0] voted, mean;
  logic          differ;
  logic          valid_n, flag_n;
  logic [DW-1:0] data_n;

  rr_rstsync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  rr_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(srst_n), .start(start), .crit_in(crit_mode),
    .five_in(five_reads), .base_in(base_addr), .rd_ack(rd_ack),
    .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr), .take(take),
    .take_last(take_last), .idx(idx), .crit_q(crit_q), .five_q(five_q)
  );

  // running total restarts on the first code of each operation
  always_comb begin
    if (idx == 3'd0) acc_n = SW'(rd_data);
    else             acc_n = acc_q + SW'(rd_data);
  end

  rr_vote #(.DW(DW)) u_vote (
    .code_a(cap0_q), .code_b(cap1_q), .code_c(rd_data),
    .voted(voted), .differ(differ)
  );

  rr_mean #(.DW(DW), .SW(SW)) u_mean (
    .sum(acc_n), .by_five(five_q), .mean(mean)
  );

  always_comb begin
    valid_n = take_last;
    flag_n  = take_last && crit_q && differ;
    data_n  = crit_q ? voted : mean;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      acc_q  <= '0;
      cap0_q <= '0;
      cap1_q <= '0;
    end else if (take) begin
      acc_q <= acc_n;
      if (idx == 3'd0) cap0_q <= rd_data;
      if (idx == 3'd1) cap1_q <= rd_data;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      res_valid    <= 1'b0;
      res_disagree <= 1'b0;
    end else begin
      res_valid    <= valid_n;
      res_disagree <= flag_n;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)         res_data <= '0;
    else if (take_last)  res_data <= data_n;
  end
endmodule

// File: rtl/redread_combiner_chk.sv
module redread_combiner_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_req,
  input logic          rd_ack,
  input logic [AW-1:0] rd_addr,
  input logic          busy,
  input logic          res_valid,
  input logic          res_disagree
);
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req);

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_valid_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(rd_req && rd_ack));

  assert_flag_qualified_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_disagree |-> res_valid);

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !busy);
endmodule

bind redread_combiner redread_combiner_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_ack(rd_ack),
  .rd_addr(rd_addr), .busy(busy), .res_valid(res_valid),
  .res_disagree(res_disagree)
);

// File: tb/redread_combiner_test.sv
`timescale 1ns/1ps
module redread_combiner_test;
  localparam int AW = 8;
  localparam int DW = 8;

  logic          clk;
  logic          rst_n;
  logic          start, crit_mode, five_reads;
  logic [AW-1:0] base_addr;
  logic          rd_req, rd_ack;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic          busy, res_valid, res_disagree;
  logic [DW-1:0] res_data;

  int nchk  = 0;
  int nfail = 0;
  logic [DW-1:0] rv [5];

  redread_combiner #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .crit_mode(crit_mode),
    .five_reads(five_reads), .base_addr(base_addr), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data), .busy(busy),
    .res_valid(res_valid), .res_data(res_data), .res_disagree(res_disagree)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] hv(input int s);
    logic [31:0] x;
    x = 32'(s) * 32'h9E3779B1;
    x = x ^ (x >> 15);
    return x[23:16];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one operation; the bench plays the read port, returning rv[k] on read k
  task automatic run_op(input bit crit, input bit five, input logic [AW-1:0] base,
                        input int lat, input bit poke);
    int n, sum, exp, a, b, c;
    bit dis;
    n = crit ? 3 : (five ? 5 : 2);
    @(negedge clk);
    start = 1'b1; crit_mode = crit; five_reads = five; base_addr = base;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R8 busy after start", busy, 1);
    for (int k = 0; k < n; k++) begin
      while (!rd_req) @(negedge clk);
      chk(rd_addr == (crit ? base + AW'(k) : base), crit ? "R1 address" : "R4/R5 address",
          rd_addr, crit ? base + AW'(k) : base);
      if (poke && k == 0) begin
        start = 1'b1; crit_mode = ~crit; five_reads = ~five; base_addr = ~base;
      end
      for (int w = 0; w < lat; w++) begin
        @(negedge clk);
        chk(rd_req == 1'b1, "R6 request held", rd_req, 1);
      end
      rd_ack = 1'b1; rd_data = rv[k];
      @(negedge clk);
      rd_ack = 1'b0; start = 1'b0;
      if (k < n - 1) chk(res_valid == 1'b0, "R7 early valid", res_valid, 0);
    end
    // the cycle after the last acknowledge edge
    a = rv[0]; b = rv[1]; c = rv[2];
    if (crit) begin
      exp = (a & b) | (a & c) | (b & c);
      dis = !(a == b && b == c);
    end else begin
      sum = 0;
      for (int k = 0; k < n; k++) sum += rv[k];
      exp = five ? (sum + 2) / 5 : (sum + 1) / 2;
      dis = 1'b0;
    end
    chk(res_valid == 1'b1, "R7 valid strobe", res_valid, 1);
    chk(busy == 1'b0, "R8 idle at result", busy, 0);
    chk(res_data == DW'(exp), crit ? "R1/R2 vote result" : (five ? "R4 mean of five" : "R5 mean of two"),
        res_data, exp);
    chk(res_disagree == dis, "R3 disagree flag", res_disagree, dis);
    @(negedge clk);
    chk(res_valid == 1'b0, "R7 single-cycle strobe", res_valid, 0);
    chk(rd_req == 1'b0, "R6 idle request", rd_req, 0);
    chk(res_disagree == 1'b0, "R3 flag drops", res_disagree, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; crit_mode = 1'b0; five_reads = 1'b0;
    base_addr = '0; rd_ack = 1'b0; rd_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(rd_req == 1'b0, "R9 rd_req", rd_req, 0);
    chk(res_valid == 1'b0, "R9 res_valid", res_valid, 0);
    chk(res_disagree == 1'b0, "R9 res_disagree", res_disagree, 0);
    chk(busy == 1'b0, "R9 busy", busy, 0);

    // R2: every true value, each fault position, plus no fault (p=3)
    for (int v = 0; v < 256; v++) begin
      for (int p = 0; p < 4; p++) begin
        logic [7:0] m;
        m = hv(v * 4 + p);
        if (m == 8'd0) m = 8'd1;
        for (int k = 0; k < 3; k++) rv[k] = (k == p) ? 8'(v) ^ m : 8'(v);
        rv[3] = '0; rv[4] = '0;
        run_op(1'b1, 1'b0, 8'(v * 7), (v + p) % 3, (v % 9) == 0);
      end
    end

    // R1/R3: three arbitrary, mostly different copies, including address wrap
    for (int i = 0; i < 64; i++) begin
      for (int k = 0; k < 3; k++) rv[k] = hv(1000 + i * 3 + k);
      run_op(1'b1, 1'b0, (i < 4) ? 8'(254 + i) : 8'(i), i % 4, (i % 5) == 0);
    end

    // R4: five reads, extremes then spread sums near rounding points
    for (int i = 0; i < 360; i++) begin
      for (int k = 0; k < 5; k++) begin
        if (i == 0)      rv[k] = 8'hFF;
        else if (i == 1) rv[k] = 8'h00;
        else if (i < 40) rv[k] = (k == 0) ? 8'(i - 2) : 8'h00;
        else             rv[k] = hv(5000 + i * 5 + k);
      end
      run_op(1'b0, 1'b1, 8'(i), i % 3, (i % 11) == 0);
    end

    // R5: two reads, odd and even sums, extremes
    for (int i = 0; i < 300; i++) begin
      rv[0] = (i < 256) ? 8'(i) : 8'hFF;
      rv[1] = (i < 128) ? 8'(i + 1) : ((i < 256) ? hv(9000 + i) : 8'(i - 256 + 200));
      rv[2] = '0; rv[3] = '0; rv[4] = '0;
      run_op(1'b0, 1'b0, 8'(i * 3), i % 3, (i % 13) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule